// File: doc/BRIEF.md
# Control-Register Port Write Master

This block carries out a single write into a PHY's internal control register over a narrow handshake port. The port has a 16-bit data-in bus, three command strobes and one acknowledge line. A host hands over a register address and a write value. The block then runs three commands in a fixed order: capture address, capture data, and commit the write. Each command is a full four-phase handshake with the PHY.

For each command the block does the following:

1. It places the value on the data-in bus while every strobe is low.
2. On the next clock it raises the strobe for that command.
3. It waits for the acknowledge to rise, then drops the strobe while the data stays put.
4. It waits for the acknowledge to fall before moving on.

The acknowledge comes from another clock domain, so it passes through a flop synchronizer before the block looks at it. Every wait is bounded by a cycle counter. If any wait runs out, the sequence is abandoned. The port is then cleared and an error pulse is reported.

The request side is a valid/ready channel. `req_ready_o` is high only while the block is idle. A request is taken on the clock edge where `req_valid_i` and `req_ready_o` are both high, and the address and data are sampled only at that edge. While a write is in progress, ready stays low, so `req_valid_i` can be held or pulsed freely without effect. The status outputs are plain signals: busy, a done pulse and an error pulse.

Top module: `crp_write_master`

## Requirements
- R1: After reset, `phy_cmd_o` is 0, `phy_din_o` is 0, `busy_o`, `done_o` and `err_o` are 0, and `req_ready_o` is 1.
- R2: An accepted write produces exactly three strobe assertions, in this order: bit 0 of `phy_cmd_o` (capture address), then bit 1 (capture data), then bit 2 (commit). At most one bit is ever high.
- R3: During the capture-address command, `phy_din_o` carries the request address. During the capture-data and commit commands, it carries the request data.
- R4: `phy_din_o` already holds its value in the cycle before a strobe rises. It does not change while a strobe is high.
- R5: A strobe is dropped only after the synchronized acknowledge is seen high. The next command starts only after the synchronized acknowledge is seen low.
- R6: The acknowledge passes through a synchronizer of SYNC_STAGES flops (default 2). A strobe falls on the third rising clock edge after the acknowledge input rises.
- R7: If the acknowledge does not rise within TIMEOUT_CYC cycles of a strobe rising, the strobe drops and `err_o` pulses exactly TIMEOUT_CYC cycles after the strobe rose. No done pulse is given.
- R8: If the acknowledge does not fall within TIMEOUT_CYC cycles of a strobe dropping, `err_o` pulses and the remaining commands are not issued.
- R9: When `err_o` is high, `phy_cmd_o` and `phy_din_o` are 0. The block is idle and ready in the next cycle.
- R10: A completed write gives a single-cycle `done_o` pulse after the acknowledge of the commit command falls. In that cycle `phy_din_o` is cleared, `busy_o` is low, and `done_o` and `err_o` are never high together.
- R11: `req_valid_i` raised while a write is in progress is not accepted. No extra strobes follow, either during or after that write.
- R12: `req_ready_o` is high exactly when the block is idle. An accepted request makes `busy_o` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host offers a write request |
| req_ready_o | output | 1 | Block is idle and will accept a request |
| req_addr_i | input | 16 | Register address, sampled on acceptance |
| req_data_i | input | 16 | Write value, sampled on acceptance |
| busy_o | output | 1 | A write sequence is in progress |
| done_o | output | 1 | One-cycle pulse: write completed |
| err_o | output | 1 | One-cycle pulse: an acknowledge wait timed out |
| phy_din_o | output | 16 | Data-in bus to the PHY control port |
| phy_cmd_o | output | 3 | Strobes: bit 0 capture address, bit 1 capture data, bit 2 commit |
| phy_ack_i | input | 1 | Acknowledge from the PHY, asynchronous |

## Verification
The assertions assume that the acknowledge only rises while a strobe is high and only falls after that strobe has dropped. They also assume that request fields matter only at the accepting edge. The strobe-drop check relies on the first of these, because a dropped strobe without an error is taken as proof that the synchronized acknowledge was seen.

The bench's PHY responder keeps within these assumptions. It raises the acknowledge only after it samples a live strobe, and it releases the acknowledge only once all strobes are low. It breaks the handshake on purpose in two ways only: by withholding the acknowledge, or by holding it high. Either fault is confined to one chosen command, so that each timeout path is reached.

// File: rtl/crp_pkg.sv
package crp_pkg;

  // Command position in the write sequence; the value is also the strobe bit index.
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_RAISE   = 2'd2,
    ST_RELEASE = 2'd3
  } state_e;

  localparam int unsigned NUM_CMDS = 3;

  function automatic logic [NUM_CMDS-1:0] strobe_of(phase_e p);
    return NUM_CMDS'(1) << p;
  endfunction

endpackage

// File: rtl/crp_ack_sync.sv
module crp_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $fatal(1, "crp_ack_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/crp_wait_timer.sv
module crp_wait_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !expired_o)  cnt_q <= cnt_q + CW'(1);
  end

  assign expired_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/crp_phase_seq.sv
module crp_phase_seq
  import crp_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [BUS_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]    data_i,
  input  logic                ack_i,
  input  logic                expired_i,
  output logic [NUM_CMDS-1:0] cmd_o,
  output logic [BUS_W-1:0]    din_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic                tmr_clr_o,
  output logic                tmr_run_o
);
  state_e                state_q, state_n;
  phase_e                phase_q, phase_n;
  logic [BUS_W-1:0]      data_q, data_n;
  logic [BUS_W-1:0]      din_q, din_n;
  logic [NUM_CMDS-1:0]   cmd_q, cmd_n;
  logic                  done_q, done_n;
  logic                  err_q, err_n;

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    data_n  = data_q;
    din_n   = din_q;
    cmd_n   = cmd_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_SETUP;
          phase_n = PH_ADDR;
          data_n  = data_i;
          din_n   = addr_i;
        end
      end
      ST_SETUP: begin
        state_n = ST_RAISE;
        cmd_n   = strobe_of(phase_q);
      end
      ST_RAISE: begin
        if (ack_i) begin
          state_n = ST_RELEASE;
          cmd_n   = '0;
        end else if (expired_i) begin
          state_n = ST_IDLE;
          cmd_n   = '0;
          din_n   = '0;
          err_n   = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!ack_i) begin
          if (phase_q == PH_WRITE) begin
            state_n = ST_IDLE;
            din_n   = '0;
            done_n  = 1'b1;
          end else begin
            state_n = ST_SETUP;
            phase_n = phase_e'(phase_q + 2'd1);
            din_n   = data_q;
          end
        end else if (expired_i) begin
          state_n = ST_IDLE;
          cmd_n   = '0;
          din_n   = '0;
          err_n   = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
      data_q  <= '0;
      din_q   <= '0;
      cmd_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      data_q  <= data_n;
      din_q   <= din_n;
      cmd_q   <= cmd_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign cmd_o     = cmd_q;
  assign din_o     = din_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign tmr_clr_o = (state_n != state_q);
  assign tmr_run_o = (state_q == ST_RAISE) || (state_q == ST_RELEASE);
endmodule

// File: rtl/crp_write_master.sv
module crp_write_master
  import crp_pkg::*;
#(
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned TIMEOUT_CYC = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [BUS_W-1:0]    req_addr_i,
  input  logic [BUS_W-1:0]    req_data_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [BUS_W-1:0]    phy_din_o,
  output logic [NUM_CMDS-1:0] phy_cmd_o,
  input  logic                phy_ack_i
);
  logic ack_s;
  logic expired;
  logic tmr_clr;
  logic tmr_run;
  logic busy;

  crp_ack_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (phy_ack_i),
    .q_o    (ack_s)
  );

  crp_wait_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .expired_o (expired)
  );

  crp_phase_seq #(.BUS_W(BUS_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (req_valid_i && !busy),
    .addr_i    (req_addr_i),
    .data_i    (req_data_i),
    .ack_i     (ack_s),
    .expired_i (expired),
    .cmd_o     (phy_cmd_o),
    .din_o     (phy_din_o),
    .busy_o    (busy),
    .done_o    (done_o),
    .err_o     (err_o),
    .tmr_clr_o (tmr_clr),
    .tmr_run_o (tmr_run)
  );

  assign busy_o      = busy;
  assign req_ready_o = !busy;
endmodule

// File: rtl/crp_write_master_chk.sv
module crp_write_master_chk #(
  parameter int unsigned BUS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [BUS_W-1:0] phy_din_o,
  input logic [2:0]       phy_cmd_o,
  input logic             ack_s
);
  assert_cmd_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phy_cmd_o));

  assert_din_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|phy_cmd_o) |-> $stable(phy_din_o));

  assert_din_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|phy_cmd_o) && $past(|phy_cmd_o)) |-> $stable(phy_din_o));

  assert_drop_on_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(|phy_cmd_o) && !err_o) |-> $past(ack_s));

  assert_err_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (phy_cmd_o == 3'b000 && phy_din_o == '0));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_accept_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> busy_o);
endmodule

bind crp_write_master crp_write_master_chk #(.BUS_W(BUS_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .phy_din_o   (phy_din_o),
  .phy_cmd_o   (phy_cmd_o),
  .ack_s       (ack_s)
);

// File: tb/test_crp_write_master.sv
module test_crp_write_master;
  localparam int unsigned BW = 16;
  localparam int unsigned TO = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [BW-1:0] req_addr = '0;
  logic [BW-1:0] req_data = '0;
  logic          busy, done, err;
  logic [BW-1:0] din;
  logic [2:0]    cmd;
  logic          ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed { logic [2:0] c; logic [BW-1:0] d; } item_t;
  item_t exp_q[$];

  int         ack_dly = 0;
  logic [2:0] stall_mask = '0;
  logic [2:0] stick_mask = '0;

  always #2 clk = ~clk;

  crp_write_master #(.BUS_W(BW), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) i_crp_write_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data), .busy_o(busy), .done_o(done),
    .err_o(err), .phy_din_o(din), .phy_cmd_o(cmd), .phy_ack_i(ack));

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // Monitor, scoreboard and PHY responder, all away from the active edge.
  logic [2:0]    prev_cmd = '0;
  logic [BW-1:0] prev_din = '0;
  logic [2:0]    last_cmd = '0;
  int            dcnt = 0;
  int            lat = 0;
  bit            latv = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cmd == 3'b000 && cmd != 3'b000) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2 unexpected strobe", cmd, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(cmd == it.c, "R2 strobe order", cmd, it.c);
          chk(din == it.d, "R3 data-in value", din, it.d);
        end
        chk(din == prev_din, "R4 data-in set before strobe", din, prev_din);
      end
      if (prev_cmd != 3'b000 && cmd != 3'b000)
        chk(din == prev_din, "R4 data-in held under strobe", din, prev_din);
      if (latv) begin
        if (cmd != 3'b000) lat++;
        else begin
          latv = 0;
          if (!err) chk(lat == 2, "R6 synchronizer latency", lat, 2);
        end
      end
      if (cmd != 3'b000) last_cmd = cmd;
      if (!ack) begin
        if (cmd != 3'b000 && (cmd & stall_mask) == 3'b000) begin
          if (dcnt >= ack_dly) begin ack = 1'b1; lat = 0; latv = 1; dcnt = 0; end
          else dcnt++;
        end else dcnt = 0;
      end else if (cmd == 3'b000 && (last_cmd & stick_mask) == 3'b000) begin
        ack = 1'b0;
      end
    end
    prev_cmd = cmd;
    prev_din = din;
  end

  task automatic run_write(input logic [BW-1:0] a, input logic [BW-1:0] d, input int dly,
                           input logic [2:0] stall, input logic [2:0] stick,
                           input bit expect_ok, input bit poke, input bit chk_run, input string tag);
    logic [2:0] bits [3];
    bit got_done = 0, got_err = 0;
    int run = 0, n = 0;
    bits[0] = 3'b001; bits[1] = 3'b010; bits[2] = 3'b100;
    for (int i = 0; i < 3; i++) begin
      item_t it;
      it.c = bits[i];
      it.d = (i == 0) ? a : d;
      exp_q.push_back(it);
      if ((bits[i] & (stall | stick)) != 3'b000) break;
    end
    ack_dly = dly; stall_mask = stall; stick_mask = stick;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1 && req_ready == 1'b0, "R12 busy after accept", {busy, req_ready}, 2'b10);
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = ~a; req_data = ~d;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R11 not ready while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!got_done && !got_err && n < 4000) begin
      @(negedge clk);
      n++;
      if (done) got_done = 1;
      if (err) got_err = 1;
      else if (cmd != 3'b000) run++;
      else run = 0;
    end
    if (expect_ok) chk(got_done && !got_err, {tag, " write completes"}, {got_done, got_err}, 2'b10);
    else           chk(got_err && !got_done, {tag, " timeout reported"}, {got_done, got_err}, 2'b01);
    if (chk_run) chk(run == TO, "R7 timeout length", run, TO);
    chk(cmd == 3'b000 && din == '0, "R9 port cleared at end", {cmd, din}, 0);
    @(negedge clk);
    chk(!done && !err, "R10 single-cycle status pulse", {done, err}, 0);
    chk(!busy && req_ready, "R9 idle after end", {busy, req_ready}, 2'b01);
    chk(exp_q.size() == 0, "R2 all commands issued", exp_q.size(), 0);
    exp_q.delete();
    stall_mask = '0; stick_mask = '0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (cmd != 3'b000) chk(0, "R11 no strobe after end", cmd, 0);
    end
    chk(!busy, "R11 stays idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd == 3'b000 && din == '0, "R1 reset port", {cmd, din}, 0);
    chk(!busy && !done && !err && req_ready, "R1 reset status",
        {busy, done, err, req_ready}, 4'b0001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_write(16'h0015, 16'hA409, 1, 3'b000, 3'b000, 1, 0, 0, "R10");
    run_write(16'h1010, 16'h0080, 3, 3'b000, 3'b000, 1, 0, 0, "R10");
    run_write(16'hFFFF, 16'h0000, 0, 3'b000, 3'b000, 1, 1, 0, "R11");
    run_write(16'h0012, 16'hA000, 0, 3'b001, 3'b000, 0, 0, 1, "R7");
    run_write(16'h0033, 16'h5A5A, 2, 3'b100, 3'b000, 0, 0, 0, "R7");
    run_write(16'h4444, 16'h1234, 1, 3'b000, 3'b010, 0, 0, 0, "R8");
    run_write(16'h8001, 16'h7FFE, 0, 3'b000, 3'b000, 1, 0, 0, "R5");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule